// File: doc/BRIEF.md
# DMA Port Byte-Stream Register Parser

This block sits behind the single write port of a one-channel DMA controller and turns the stream of bytes written there into configuration fields and command pulses. No separate cycle selects a register. Each byte that arrives while the parser is idle is a base byte, and fixed bit patterns in it pick one of seven register groups. The remaining bits of the base byte carry field values, and some of them announce that further bytes of the same group will follow.

Follow-on bytes are taken in a fixed order, from the lowest flagged bit of the base byte up to the highest. Fields that are not flagged are skipped. While follow-on bytes are pending, every written byte is stored as data, whatever its bit pattern. Once the last one is stored, the next byte is decoded as a base byte again. The command group produces one-cycle pulses for load, continue, enable, disable and read-mask-follows. The transfer engine and the read-back path use these fields and pulses. Neither is part of this block.

Top module: `dmap_parser`

## Requirements
- R1: After reset, no follow-on byte is pending, all fields are zero except the read mask, which is 0x7F, and all strobes are low.
- R2: A base byte is decoded by pattern. With bit 7 clear: if bits 1:0 are nonzero it is group 0; if bits 1:0 are 00 and bit 2 is set it is group 1; otherwise it is group 2. With bit 7 set, bits 1:0 select the group: 00 is group 3, 01 is group 4 and 11 is group 6. Bits 1:0 = 10 give group 5 only when bits 6 and 2 are both clear (10xxx010); any other base byte is ignored and changes nothing.
- R3: A group 0 base byte stores bit 2 as the direction (1 = A to B) and bits 1:0 as the operation code.
- R4: In group 0, bits 3, 4, 5 and 6 flag follow-on bytes for port A address low, port A address high, length low and length high. The flagged bytes are consumed in that bit order and unflagged fields are skipped.
- R5: A group 1 or group 2 base byte stores bit 3 as the I/O flag and bits 5:4 as the address step mode for port A or port B. Bit 6 flags a timing byte, whose bits 1:0 become that port's cycle-length code.
- R6: In a port B timing byte, bit 5 flags one further byte that loads the 8-bit prescaler. Without that bit, the parser returns to base state straight after the timing byte.
- R7: A group 4 base byte sets burst mode only when bits 6:5 are 10 and clears it for any other value. Bit 2 flags the port B address low byte and bit 3 flags the port B address high byte, taken in that order.
- R8: A group 5 base byte stores bit 5 as auto-restart and bit 4 as chip-enable/wait multiplexing. A group 3 base byte with bit 6 set pulses the enable strobe.
- R9: The command bytes 0xCF, 0xD3, 0x87 and 0x83 each raise exactly one strobe (load, continue, enable, disable) for exactly the one cycle after the write.
- R10: Command 0xBB pulses the read-mask strobe and makes the next byte the read mask. Any other group 6 byte (for example 0xC3 or 0x8B) raises no strobe and changes no field.
- R11: While follow-on bytes are pending, follow_busy is high and a written byte is stored as data even if it matches a command pattern. follow_busy drops after the last pending byte.
- R12: With wr_en low, no field and no parser state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | A byte is written to the port this cycle |
| wr_data | input | 8 | Written byte |
| follow_busy | output | 1 | Follow-on bytes are pending |
| dir_a2b | output | 1 | Transfer direction, 1 = port A to port B |
| xfer_op | output | 2 | Group 0 operation code |
| a_addr | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| a_is_io | output | 1 | Port A targets I/O space |
| a_step | output | 2 | Port A address step mode |
| a_cycles | output | 2 | Port A cycle-length code |
| b_is_io | output | 1 | Port B targets I/O space |
| b_step | output | 2 | Port B address step mode |
| b_cycles | output | 2 | Port B cycle-length code |
| b_prescale | output | 8 | Fixed-time transfer prescaler |
| b_addr | output | 16 | Port B start address |
| burst_mode | output | 1 | 1 = burst, 0 = continuous |
| auto_restart | output | 1 | Restart automatically at block end |
| ce_wait_mux | output | 1 | Chip-enable/wait multiplexing selected |
| read_mask | output | 8 | Read-back mask |
| stb_load | output | 1 | Load command pulse |
| stb_continue | output | 1 | Continue command pulse |
| stb_enable | output | 1 | Enable pulse (command or group 3) |
| stb_disable | output | 1 | Disable command pulse |
| stb_rmask | output | 1 | Read-mask-follows pulse |

## Verification
A base byte with all four group 0 flags set is compared with one that flags only the first and last fields. This separates an in-order consumer from one that fills fields by byte count. Follow-on bytes that look like commands (0xCF used as a timing byte) show whether data bytes are wrongly decoded. Near-miss base bytes such as 0xC2, 0xC3 and 0x80 separate exact pattern matching from loose matching. A port B timing byte is sent once with its prescaler flag set and once without, which tests the chained follow-on. Reset arrives in the middle of a follow-on sequence to show that pending state is discarded.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    GRP_NONE, GRP_0, GRP_1, GRP_2, GRP_3, GRP_4, GRP_5, GRP_6
  } grp_e;

  // follow-on field slots; lower index is consumed first
  localparam int F_ALO   = 0;
  localparam int F_AHI   = 1;
  localparam int F_LLO   = 2;
  localparam int F_LHI   = 3;
  localparam int F_ATIM  = 4;
  localparam int F_BTIM  = 5;
  localparam int F_BPRE  = 6;
  localparam int F_BLO   = 7;
  localparam int F_BHI   = 8;
  localparam int F_RMASK = 9;
  localparam int NFLD    = 10;

  localparam logic [BYTE_W-1:0] CMD_LOAD  = 8'hCF;
  localparam logic [BYTE_W-1:0] CMD_CONT  = 8'hD3;
  localparam logic [BYTE_W-1:0] CMD_EN    = 8'h87;
  localparam logic [BYTE_W-1:0] CMD_DIS   = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_RMASK = 8'hBB;

  typedef struct packed {
    logic load;
    logic cont;
    logic en;
    logic dis;
    logic rmf;
  } stb_t;

  typedef struct packed {
    logic              dir_a2b;
    logic [1:0]        op;
    logic [ADDR_W-1:0] a_addr;
    logic [ADDR_W-1:0] blk_len;
    logic              a_io;
    logic [1:0]        a_step;
    logic [1:0]        a_cyc;
    logic              b_io;
    logic [1:0]        b_step;
    logic [1:0]        b_cyc;
    logic [BYTE_W-1:0] b_pre;
    logic [ADDR_W-1:0] b_addr;
    logic              burst;
    logic              auto_rst;
    logic              ce_wait;
    logic [BYTE_W-1:0] rmask;
  } cfg_t;

endpackage

// File: rtl/dmap_base_decode.sv
module dmap_base_decode
  import dmap_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output grp_e              grp,
  output logic [NFLD-1:0]   flags,
  output stb_t              cmd
);

  always_comb begin
    grp = GRP_NONE;
    if (!byte_in[7]) begin
      if (byte_in[1:0] != 2'b00) grp = GRP_0;
      else if (byte_in[2])       grp = GRP_1;
      else                       grp = GRP_2;
    end else begin
      case (byte_in[1:0])
        2'b00:   grp = GRP_3;
        2'b01:   grp = GRP_4;
        2'b11:   grp = GRP_6;
        default: grp = (!byte_in[6] && !byte_in[2]) ? GRP_5 : GRP_NONE;
      endcase
    end
  end

  always_comb begin
    flags = '0;
    case (grp)
      GRP_0: begin
        flags[F_ALO] = byte_in[3];
        flags[F_AHI] = byte_in[4];
        flags[F_LLO] = byte_in[5];
        flags[F_LHI] = byte_in[6];
      end
      GRP_1: flags[F_ATIM] = byte_in[6];
      GRP_2: flags[F_BTIM] = byte_in[6];
      GRP_4: begin
        flags[F_BLO] = byte_in[2];
        flags[F_BHI] = byte_in[3];
      end
      GRP_6: flags[F_RMASK] = (byte_in == CMD_RMASK);
      default: flags = '0;
    endcase
  end

  always_comb begin
    cmd = '0;
    if (grp == GRP_3) begin
      cmd.en = byte_in[6];
    end else if (grp == GRP_6) begin
      cmd.load = (byte_in == CMD_LOAD);
      cmd.cont = (byte_in == CMD_CONT);
      cmd.en   = (byte_in == CMD_EN);
      cmd.dis  = (byte_in == CMD_DIS);
      cmd.rmf  = (byte_in == CMD_RMASK);
    end
  end

endmodule

// File: rtl/dmap_follow_seq.sv
module dmap_follow_seq
  import dmap_pkg::*;
#(
  parameter int NF       = NFLD,
  parameter int IDX_TIM  = F_BTIM,
  parameter int IDX_PRE  = F_BPRE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pre_flag,
  input  logic [NF-1:0] base_flags,
  output logic [NF-1:0] sel_oh,
  output logic          busy
);

  localparam logic [NF-1:0] ONE = {{(NF-1){1'b0}}, 1'b1};

  logic [NF-1:0] pend_q;
  logic [NF-1:0] pend_d;

  // lowest pending slot is the one the current byte fills
  always_comb begin
    sel_oh = pend_q & (~pend_q + ONE);
    busy   = |pend_q;
  end

  always_comb begin
    pend_d = pend_q;
    if (!busy) begin
      pend_d = base_flags;
    end else begin
      pend_d = pend_q & ~sel_oh;
      if (sel_oh[IDX_TIM] && pre_flag) pend_d[IDX_PRE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= '0;
    else if (wr_en) pend_q <= pend_d;
  end

endmodule

// File: rtl/dmap_regfile.sv
module dmap_regfile
  import dmap_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RMASK_INIT = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              base_ok,
  input  grp_e              grp,
  input  logic [NFLD-1:0]   sel_oh,
  output cfg_t              cfg
);

  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (base_ok) begin
      case (grp)
        GRP_0: begin
          cfg_d.dir_a2b = wr_data[2];
          cfg_d.op      = wr_data[1:0];
        end
        GRP_1: begin
          cfg_d.a_io   = wr_data[3];
          cfg_d.a_step = wr_data[5:4];
        end
        GRP_2: begin
          cfg_d.b_io   = wr_data[3];
          cfg_d.b_step = wr_data[5:4];
        end
        GRP_4: cfg_d.burst = (wr_data[6:5] == 2'b10);
        GRP_5: begin
          cfg_d.auto_rst = wr_data[5];
          cfg_d.ce_wait  = wr_data[4];
        end
        default: cfg_d = cfg_q;
      endcase
    end else begin
      if (sel_oh[F_ALO])   cfg_d.a_addr[BYTE_W-1:0]       = wr_data;
      if (sel_oh[F_AHI])   cfg_d.a_addr[ADDR_W-1:BYTE_W]  = wr_data;
      if (sel_oh[F_LLO])   cfg_d.blk_len[BYTE_W-1:0]      = wr_data;
      if (sel_oh[F_LHI])   cfg_d.blk_len[ADDR_W-1:BYTE_W] = wr_data;
      if (sel_oh[F_ATIM])  cfg_d.a_cyc                    = wr_data[1:0];
      if (sel_oh[F_BTIM])  cfg_d.b_cyc                    = wr_data[1:0];
      if (sel_oh[F_BPRE])  cfg_d.b_pre                    = wr_data;
      if (sel_oh[F_BLO])   cfg_d.b_addr[BYTE_W-1:0]       = wr_data;
      if (sel_oh[F_BHI])   cfg_d.b_addr[ADDR_W-1:BYTE_W]  = wr_data;
      if (sel_oh[F_RMASK]) cfg_d.rmask                    = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      cfg_q.rmask <= RMASK_INIT;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/dmap_cmd_strobe.sv
module dmap_cmd_strobe
  import dmap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  stb_t cmd,
  output stb_t stb
);

  stb_t stb_q;
  stb_t stb_d;

  always_comb begin
    stb_d = fire ? cmd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  assign stb = stb_q;

endmodule

// File: rtl/dmap_parser.sv
module dmap_parser
  import dmap_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RMASK_INIT  = 8'h7F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              follow_busy,
  output logic              dir_a2b,
  output logic [1:0]        xfer_op,
  output logic [ADDR_W-1:0] a_addr,
  output logic [ADDR_W-1:0] blk_len,
  output logic              a_is_io,
  output logic [1:0]        a_step,
  output logic [1:0]        a_cycles,
  output logic              b_is_io,
  output logic [1:0]        b_step,
  output logic [1:0]        b_cycles,
  output logic [BYTE_W-1:0] b_prescale,
  output logic [ADDR_W-1:0] b_addr,
  output logic              burst_mode,
  output logic              auto_restart,
  output logic              ce_wait_mux,
  output logic [BYTE_W-1:0] read_mask,
  output logic              stb_load,
  output logic              stb_continue,
  output logic              stb_enable,
  output logic              stb_disable,
  output logic              stb_rmask
);

  // reset: asserted asynchronously, released after SYNC_STAGES clocks
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  grp_e            grp;
  logic [NFLD-1:0] flags;
  logic [NFLD-1:0] sel_oh;
  stb_t            cmd;
  stb_t            stb;
  cfg_t            cfg;
  logic            busy;
  logic            base_ok;

  dmap_base_decode u_dec (
    .byte_in (wr_data),
    .grp     (grp),
    .flags   (flags),
    .cmd     (cmd)
  );

  dmap_follow_seq #(
    .NF      (NFLD),
    .IDX_TIM (F_BTIM),
    .IDX_PRE (F_BPRE)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .pre_flag   (wr_data[5]),
    .base_flags (flags),
    .sel_oh     (sel_oh),
    .busy       (busy)
  );

  assign base_ok = !busy;

  dmap_regfile #(
    .RMASK_INIT (RMASK_INIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .base_ok (base_ok),
    .grp     (grp),
    .sel_oh  (sel_oh),
    .cfg     (cfg)
  );

  dmap_cmd_strobe u_stb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .fire  (wr_en && base_ok),
    .cmd   (cmd),
    .stb   (stb)
  );

  assign follow_busy  = busy;
  assign dir_a2b      = cfg.dir_a2b;
  assign xfer_op      = cfg.op;
  assign a_addr       = cfg.a_addr;
  assign blk_len      = cfg.blk_len;
  assign a_is_io      = cfg.a_io;
  assign a_step       = cfg.a_step;
  assign a_cycles     = cfg.a_cyc;
  assign b_is_io      = cfg.b_io;
  assign b_step       = cfg.b_step;
  assign b_cycles     = cfg.b_cyc;
  assign b_prescale   = cfg.b_pre;
  assign b_addr       = cfg.b_addr;
  assign burst_mode   = cfg.burst;
  assign auto_restart = cfg.auto_rst;
  assign ce_wait_mux  = cfg.ce_wait;
  assign read_mask    = cfg.rmask;
  assign stb_load     = stb.load;
  assign stb_continue = stb.cont;
  assign stb_enable   = stb.en;
  assign stb_disable  = stb.dis;
  assign stb_rmask    = stb.rmf;

endmodule

// File: rtl/dmap_parser_chk.sv
module dmap_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        follow_busy,
  input logic [15:0] a_addr,
  input logic [15:0] blk_len,
  input logic [15:0] b_addr,
  input logic [7:0]  read_mask,
  input logic        stb_load,
  input logic        stb_continue,
  input logic        stb_enable,
  input logic        stb_disable,
  input logic        stb_rmask
);

  logic [4:0] stbs;
  assign stbs = {stb_load, stb_continue, stb_enable, stb_disable, stb_rmask};

  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs));

  p_strobe_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stbs != 5'b0) |-> $past(wr_en));

  p_load_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_load |=> !stb_load);

  p_rmask_arms_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rmask |-> follow_busy);

  p_no_strobe_from_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stbs != 5'b0) |-> !$past(follow_busy));

  p_hold_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(a_addr) && $stable(blk_len) && $stable(b_addr)
               && $stable(read_mask) && $stable(follow_busy));

endmodule

bind dmap_parser dmap_parser_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .follow_busy  (follow_busy),
  .a_addr       (a_addr),
  .blk_len      (blk_len),
  .b_addr       (b_addr),
  .read_mask    (read_mask),
  .stb_load     (stb_load),
  .stb_continue (stb_continue),
  .stb_enable   (stb_enable),
  .stb_disable  (stb_disable),
  .stb_rmask    (stb_rmask)
);

// File: tb/dmap_parser_test.sv
`timescale 1ns/1ps
module dmap_parser_test;

  localparam int CYC = 20;

  localparam int S_BUSY = 0,  S_DIR = 1,  S_OP = 2,   S_AADDR = 3, S_LEN = 4;
  localparam int S_AIO = 5,   S_ASTEP = 6, S_ACYC = 7, S_BIO = 8,  S_BSTEP = 9;
  localparam int S_BCYC = 10, S_PRE = 11, S_BADDR = 12, S_BURST = 13, S_ARST = 14;
  localparam int S_CEW = 15,  S_RMASK = 16, S_STB = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        follow_busy, dir_a2b, a_is_io, b_is_io, burst_mode;
  logic        auto_restart, ce_wait_mux;
  logic        stb_load, stb_continue, stb_enable, stb_disable, stb_rmask;
  logic [1:0]  xfer_op, a_step, a_cycles, b_step, b_cycles;
  logic [15:0] a_addr, blk_len, b_addr;
  logic [7:0]  b_prescale, read_mask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #(CYC/2) clk = ~clk;

  dmap_parser uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .follow_busy(follow_busy), .dir_a2b(dir_a2b), .xfer_op(xfer_op),
    .a_addr(a_addr), .blk_len(blk_len), .a_is_io(a_is_io), .a_step(a_step),
    .a_cycles(a_cycles), .b_is_io(b_is_io), .b_step(b_step), .b_cycles(b_cycles),
    .b_prescale(b_prescale), .b_addr(b_addr), .burst_mode(burst_mode),
    .auto_restart(auto_restart), .ce_wait_mux(ce_wait_mux), .read_mask(read_mask),
    .stb_load(stb_load), .stb_continue(stb_continue), .stb_enable(stb_enable),
    .stb_disable(stb_disable), .stb_rmask(stb_rmask)
  );

  function automatic logic [31:0] probe(input int sel);
    case (sel)
      S_BUSY:  return {31'b0, follow_busy};
      S_DIR:   return {31'b0, dir_a2b};
      S_OP:    return {30'b0, xfer_op};
      S_AADDR: return {16'b0, a_addr};
      S_LEN:   return {16'b0, blk_len};
      S_AIO:   return {31'b0, a_is_io};
      S_ASTEP: return {30'b0, a_step};
      S_ACYC:  return {30'b0, a_cycles};
      S_BIO:   return {31'b0, b_is_io};
      S_BSTEP: return {30'b0, b_step};
      S_BCYC:  return {30'b0, b_cycles};
      S_PRE:   return {24'b0, b_prescale};
      S_BADDR: return {16'b0, b_addr};
      S_BURST: return {31'b0, burst_mode};
      S_ARST:  return {31'b0, auto_restart};
      S_CEW:   return {31'b0, ce_wait_mux};
      S_RMASK: return {24'b0, read_mask};
      default: return {27'b0, stb_load, stb_continue, stb_enable, stb_disable, stb_rmask};
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = probe(it.sel);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic ex(input int sel, input logic [31:0] v, input string req);
    item_t it;
    it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wb(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5 rst_n = 1'b0;
    do_reset();
    // R1 reset state
    ex(S_BUSY, 0, "R1"); ex(S_AADDR, 0, "R1"); ex(S_LEN, 0, "R1");
    ex(S_BADDR, 0, "R1"); ex(S_RMASK, 32'h7F, "R1"); ex(S_STB, 0, "R1");
    ex(S_BURST, 0, "R1"); ex(S_PRE, 0, "R1");

    // R3 R4: all group 0 fields in order
    wb(8'h7D); ex(S_BUSY, 1, "R4"); ex(S_DIR, 1, "R3"); ex(S_OP, 1, "R3");
    wb(8'h34); ex(S_BUSY, 1, "R4");
    wb(8'h12);
    wb(8'h78);
    wb(8'h56); ex(S_BUSY, 0, "R11"); ex(S_AADDR, 32'h1234, "R4"); ex(S_LEN, 32'h5678, "R4");

    // R4 skipping: D3 and D6 only
    wb(8'h49); ex(S_BUSY, 1, "R4"); ex(S_DIR, 0, "R3"); ex(S_OP, 1, "R3");
    wb(8'hAB); ex(S_BUSY, 1, "R4"); ex(S_AADDR, 32'h12AB, "R4");
    wb(8'hCD); ex(S_BUSY, 0, "R4"); ex(S_LEN, 32'hCD78, "R4"); ex(S_AADDR, 32'h12AB, "R4");

    // R2 R3: group 0 with no follow-ons
    wb(8'h02); ex(S_BUSY, 0, "R2"); ex(S_OP, 2, "R3"); ex(S_DIR, 0, "R3");

    // R5: group 1 and timing byte; R11 command-like data byte
    wb(8'h54); ex(S_BUSY, 1, "R5"); ex(S_ASTEP, 1, "R5"); ex(S_AIO, 0, "R5");
    wb(8'h02); ex(S_ACYC, 2, "R5"); ex(S_BUSY, 0, "R5");
    wb(8'h7C); ex(S_AIO, 1, "R5"); ex(S_ASTEP, 3, "R5"); ex(S_BUSY, 1, "R5");
    wb(8'hCF); ex(S_ACYC, 3, "R5"); ex(S_STB, 0, "R11"); ex(S_BUSY, 0, "R11");

    // R6: group 2 with and without prescaler follow-on
    wb(8'h68); ex(S_BIO, 1, "R5"); ex(S_BSTEP, 2, "R5"); ex(S_BUSY, 1, "R5");
    wb(8'h21); ex(S_BCYC, 1, "R5"); ex(S_BUSY, 1, "R6");
    wb(8'h99); ex(S_PRE, 32'h99, "R6"); ex(S_BUSY, 0, "R6");
    wb(8'h48); ex(S_BSTEP, 0, "R5"); ex(S_BUSY, 1, "R5");
    wb(8'h03); ex(S_BCYC, 3, "R5"); ex(S_BUSY, 0, "R6"); ex(S_PRE, 32'h99, "R6");

    // R7: group 4 modes and port B address
    wb(8'hAD); ex(S_BURST, 0, "R7"); ex(S_BUSY, 1, "R7");
    wb(8'h00); ex(S_BUSY, 1, "R7");
    wb(8'h40); ex(S_BADDR, 32'h4000, "R7"); ex(S_BUSY, 0, "R7");
    wb(8'hC9); ex(S_BURST, 1, "R7"); ex(S_BUSY, 1, "R7");
    wb(8'h5B); ex(S_BADDR, 32'h5B00, "R7"); ex(S_BUSY, 0, "R7");
    wb(8'h81); ex(S_BURST, 0, "R7"); ex(S_BUSY, 0, "R7");

    // R8: group 5; R2: near-miss 0xC2 ignored
    wb(8'hA2); ex(S_ARST, 1, "R8"); ex(S_CEW, 0, "R8");
    wb(8'h92); ex(S_ARST, 0, "R8"); ex(S_CEW, 1, "R8");
    wb(8'hC2); ex(S_ARST, 0, "R2"); ex(S_CEW, 1, "R2"); ex(S_BUSY, 0, "R2"); ex(S_STB, 0, "R2");

    // R8: group 3 enable bit
    wb(8'hC0); ex(S_STB, 32'h04, "R8");
    idle(1);   ex(S_STB, 0, "R9");
    wb(8'h80); ex(S_STB, 0, "R8");

    // R9: commands, one strobe each, one cycle
    wb(8'hCF); ex(S_STB, 32'h10, "R9");
    wb(8'hD3); ex(S_STB, 32'h08, "R9");
    wb(8'h87); ex(S_STB, 32'h04, "R9");
    wb(8'h83); ex(S_STB, 32'h02, "R9");
    idle(1);   ex(S_STB, 0, "R9");

    // R10: read mask follows
    wb(8'hBB); ex(S_STB, 32'h01, "R10"); ex(S_BUSY, 1, "R10");
    wb(8'h1F); ex(S_RMASK, 32'h1F, "R10"); ex(S_BUSY, 0, "R10"); ex(S_STB, 0, "R10");

    // R10: unknown commands ignored
    wb(8'hC3); ex(S_STB, 0, "R10"); ex(S_RMASK, 32'h1F, "R10"); ex(S_BUSY, 0, "R10");
    wb(8'h8B); ex(S_STB, 0, "R10"); ex(S_AADDR, 32'h12AB, "R10"); ex(S_BADDR, 32'h5B00, "R10");

    // R12: idle holds everything
    wb(8'h7D); ex(S_BUSY, 1, "R12");
    idle(5);
    ex(S_BUSY, 1, "R12"); ex(S_AADDR, 32'h12AB, "R12"); ex(S_LEN, 32'hCD78, "R12");
    ex(S_BADDR, 32'h5B00, "R12");

    // R1: reset during a pending follow-on sequence
    do_reset();
    ex(S_BUSY, 0, "R1"); ex(S_AADDR, 0, "R1"); ex(S_RMASK, 32'h7F, "R1"); ex(S_PRE, 0, "R1");
    wb(8'h02); ex(S_OP, 2, "R1"); ex(S_BUSY, 0, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule